// File: doc/BRIEF.md
# Page Write Load Controller

This block is the device-side front end of a byte-wide nonvolatile memory model. A host performs a burst of byte writes by pulsing a write strobe, formed as the OR of an active-low chip enable and an active-low write enable. The block samples the address when the strobe falls and the data when it rises. It gathers up to one full page of bytes into a local page buffer, with a mask that records which slots hold data. It then hands the whole page to a program engine in a single internal program cycle.

The first byte of a burst fixes the page: the upper address bits above the byte offset. Any later byte that names a different page is dropped. A later byte is also dropped if its falling edge comes more than a re-arm window after the previous accepted falling edge. When the strobe has stayed high for a silence window, the block closes the burst by itself. It then issues a one-cycle commit pulse and holds a busy flag for the program time. While busy, no byte loads are accepted. The program engine reads the buffer through a combinational read port. Slots that were not loaded read as the erased value, all ones. All windows are clock-cycle parameters. Reset is synchronous and active low. It blocks all loads and aborts a program cycle in progress.

Top module: `pwl_load_ctrl`

## Requirements
- R1: After reset, and for as long as rst_n is low, loading, busy, commit_pulse, page_err and late_err are 0 and commit_count is 0. A strobe falling edge seen while rst_n is low does not open a load window.
- R2: The byte offset (addr bits 6:0) is taken in the first cycle the strobe is seen low. Later address changes have no effect. The data byte is taken in the first cycle the strobe is seen high again. The write strobe is ce_n OR we_n, so either pin may produce the edges.
- R3: A falling edge while idle opens a load window: loading goes to 1, and commit_page takes addr bits 16:7.
- R4: Inside a window, a load whose addr bits 16:7 differ from commit_page is ignored: the buffer and mask are unchanged, and page_err becomes 1.
- R5: Inside a window, a load whose falling edge is first seen more than REARM_CYC cycles after the previous accepted falling edge is ignored, and late_err becomes 1.
- R6: If the strobe was first seen high again after the last load in cycle r, then commit_pulse is 1 for the single cycle r+SILENCE_CYC. In that same cycle busy becomes 1 and loading becomes 0.
- R7: busy stays 1 for exactly BUSY_CYC cycles. Loads during busy are ignored, set no error flag and open no window. commit_page stays stable throughout.
- R8: rd_data is the loaded byte and rd_valid is 1 for a slot loaded in the current window. An unloaded slot gives rd_data 8'hFF with rd_valid 0. commit_count equals the number of distinct loaded offsets, from 1 to 128. Loading the same offset twice keeps the last byte and counts the slot once.
- R9: Driving rst_n low during busy aborts the program cycle. busy, the mask and commit_count are 0 from the next cycle, and no commit follows.
- R10: page_err and late_err hold their value until the next window opens, and opening a window clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; blocks loads and aborts programming |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | ADDR_W | Byte address; upper bits select the page |
| din | input | DATA_W | Write data |
| rd_idx | input | OFF_W | Buffer slot read by the program engine |
| rd_data | output | DATA_W | Byte in the addressed slot, 8'hFF when not loaded |
| rd_valid | output | 1 | Addressed slot was loaded |
| loading | output | 1 | A load window is open |
| busy | output | 1 | Internal program cycle in progress |
| commit_pulse | output | 1 | One-cycle start of the program cycle |
| commit_page | output | PAGE_W | Page taken by the current or last window |
| commit_count | output | OFF_W+1 | Number of loaded slots |
| page_err | output | 1 | A load was dropped for a page mismatch |
| late_err | output | 1 | A load was dropped for arriving after the re-arm window |

## Verification
Every result has a fixed latency. Flags and buffer contents settle one cycle after the strobe edge that causes them. commit_pulse falls exactly SILENCE_CYC cycles after the first high cycle of the last load, and busy spans BUSY_CYC cycles from that point. The bench changes inputs on falling clock edges and samples outputs there. It counts those cycles explicitly from the edge it drove, checking the commit one cycle early (expecting 0) and on time (expecting 1), and checking busy on its last cycle and on the cycle after. The buffer port is combinational, so it is read a short delay after rd_idx is set.

// File: rtl/pwl_pkg.sv
package pwl_pkg;

  // Widest mask the counting helper accepts (one bit per buffer slot).
  localparam int MASK_MAX = 1024;

  typedef enum logic [1:0] {
    WIN_IDLE = 2'd0,
    WIN_LOAD = 2'd1,
    WIN_BUSY = 2'd2
  } win_state_t;

  // Number of set bits in a mask, zero-extended to MASK_MAX.
  function automatic int unsigned count_set(input logic [MASK_MAX-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < MASK_MAX; i++) n += int'(v[i]);
    return n;
  endfunction

  // Bits needed to hold values 0..maxval.
  function automatic int unsigned width_for(input int unsigned maxval);
    int unsigned w;
    w = $clog2(maxval + 1);
    return (w < 1) ? 1 : w;
  endfunction

endpackage

// File: rtl/pwl_strobe_edge.sv
module pwl_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  output logic strobe_hi,
  output logic fall,
  output logic rise
);
  logic strobe_d1;

  // The write strobe is inactive while either enable is high.
  assign strobe_hi = ce_n | we_n;

  always_ff @(posedge clk) begin
    if (!rst_n) strobe_d1 <= 1'b1;
    else        strobe_d1 <= strobe_hi;
  end

  assign fall = strobe_d1 & ~strobe_hi;
  assign rise = ~strobe_d1 & strobe_hi;
endmodule

// File: rtl/pwl_window_timers.sv
module pwl_window_timers
  import pwl_pkg::*;
#(
  parameter int REARM_CYC   = 1500,
  parameter int SILENCE_CYC = 5000,
  parameter int BUSY_CYC    = 750000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_hi,
  input  logic fall_ok,
  input  logic busy_start,
  input  logic busy,
  output logic late,
  output logic silent_done,
  output logic busy_done
);
  localparam int RW = width_for(REARM_CYC + 1);
  localparam int SW = width_for(SILENCE_CYC);
  localparam int BW = width_for(BUSY_CYC);
  localparam logic [RW-1:0] REARM_LIM = RW'(REARM_CYC);
  localparam logic [SW-1:0] SIL_LAST  = SW'(SILENCE_CYC - 1);
  localparam logic [BW-1:0] BUSY_LAST = BW'(BUSY_CYC - 1);

  logic [RW-1:0] rearm_cnt;
  logic [SW-1:0] sil_cnt;
  logic [BW-1:0] busy_cnt;

  // Cycles since the last accepted falling edge, saturating past the limit.
  always_ff @(posedge clk) begin
    if (!rst_n)                      rearm_cnt <= '0;
    else if (fall_ok)                rearm_cnt <= RW'(1);
    else if (rearm_cnt <= REARM_LIM) rearm_cnt <= rearm_cnt + RW'(1);
  end
  assign late = (rearm_cnt > REARM_LIM);

  // Consecutive cycles with the strobe high.
  always_ff @(posedge clk) begin
    if (!rst_n)               sil_cnt <= '0;
    else if (!strobe_hi)      sil_cnt <= '0;
    else if (sil_cnt != SIL_LAST) sil_cnt <= sil_cnt + SW'(1);
  end
  assign silent_done = strobe_hi && (sil_cnt == SIL_LAST);

  // Program-time counter.
  always_ff @(posedge clk) begin
    if (!rst_n)          busy_cnt <= '0;
    else if (busy_start) busy_cnt <= '0;
    else if (busy)       busy_cnt <= busy_cnt + BW'(1);
  end
  assign busy_done = busy && (busy_cnt == BUSY_LAST);
endmodule

// File: rtl/pwl_page_buffer.sv
module pwl_page_buffer #(
  parameter  int OFF_W  = 7,
  parameter  int DATA_W = 8,
  localparam int DEPTH  = 1 << OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr,
  input  logic [OFF_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [OFF_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [DEPTH-1:0]  mask
);
  logic [DEPTH-1:0][DATA_W-1:0] cells;
  logic [DEPTH-1:0]             wr_vec;

  // One write-enable per slot.
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign wr_vec[i] = wr && (wr_idx == OFF_W'(i));
  end

  // Storage has no reset; the mask tells which slots are meaningful.
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++)
      if (wr_vec[i]) cells[i] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) mask <= '0;
    else               mask <= mask | wr_vec;
  end

  // Unloaded slots read back as the erased value, all ones.
  assign rd_valid = mask[rd_idx];
  assign rd_data  = rd_valid ? cells[rd_idx] : {DATA_W{1'b1}};
endmodule

// File: rtl/pwl_load_ctrl.sv
module pwl_load_ctrl
  import pwl_pkg::*;
#(
  parameter  int ADDR_W      = 17,
  parameter  int OFF_W       = 7,
  parameter  int DATA_W      = 8,
  parameter  int REARM_CYC   = 1500,
  parameter  int SILENCE_CYC = 5000,
  parameter  int BUSY_CYC    = 750000,
  localparam int PAGE_W      = ADDR_W - OFF_W,
  localparam int DEPTH       = 1 << OFF_W,
  localparam int CNT_W       = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic [OFF_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              loading,
  output logic              busy,
  output logic              commit_pulse,
  output logic [PAGE_W-1:0] commit_page,
  output logic [CNT_W-1:0]  commit_count,
  output logic              page_err,
  output logic              late_err
);
  function automatic logic [PAGE_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  function automatic logic [OFF_W-1:0] off_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction

  win_state_t        st;
  logic [OFF_W-1:0]  off_q;
  logic              ld_pend;
  logic [DEPTH-1:0]  mask;

  logic strobe_hi, ev_fall, ev_rise;
  logic late, silent_done, busy_done;

  // Named internal events.
  logic ev_open, ev_accept, ev_reject_late, ev_reject_page, ev_commit, ev_write;

  pwl_strobe_edge u_edge (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
    .strobe_hi(strobe_hi), .fall(ev_fall), .rise(ev_rise)
  );

  assign ev_open        = (st == WIN_IDLE) && ev_fall;
  assign ev_reject_late = (st == WIN_LOAD) && ev_fall && late;
  assign ev_reject_page = (st == WIN_LOAD) && ev_fall && !late &&
                          (page_of(addr) != commit_page);
  assign ev_accept      = (st == WIN_LOAD) && ev_fall && !late &&
                          (page_of(addr) == commit_page);
  assign ev_commit      = (st == WIN_LOAD) && !ev_fall && silent_done;
  assign ev_write       = (st == WIN_LOAD) && ev_rise && ld_pend;

  pwl_window_timers #(
    .REARM_CYC(REARM_CYC), .SILENCE_CYC(SILENCE_CYC), .BUSY_CYC(BUSY_CYC)
  ) u_tmr (
    .clk(clk), .rst_n(rst_n), .strobe_hi(strobe_hi),
    .fall_ok(ev_open | ev_accept), .busy_start(ev_commit),
    .busy(busy), .late(late), .silent_done(silent_done), .busy_done(busy_done)
  );

  pwl_page_buffer #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(ev_open), .wr(ev_write),
    .wr_idx(off_q), .wr_data(din), .rd_idx(rd_idx),
    .rd_data(rd_data), .rd_valid(rd_valid), .mask(mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= WIN_IDLE;
      commit_page  <= '0;
      off_q        <= '0;
      ld_pend      <= 1'b0;
      page_err     <= 1'b0;
      late_err     <= 1'b0;
      commit_pulse <= 1'b0;
    end else begin
      commit_pulse <= 1'b0;
      unique case (st)
        WIN_IDLE: begin
          if (ev_open) begin
            st          <= WIN_LOAD;
            commit_page <= page_of(addr);
            off_q       <= off_of(addr);
            ld_pend     <= 1'b1;
            page_err    <= 1'b0;
            late_err    <= 1'b0;
          end
        end
        WIN_LOAD: begin
          if (ev_reject_late) late_err <= 1'b1;
          if (ev_reject_page) page_err <= 1'b1;
          if (ev_accept) begin
            off_q   <= off_of(addr);
            ld_pend <= 1'b1;
          end else if (ev_write) begin
            ld_pend <= 1'b0;
          end
          if (ev_commit) begin
            st           <= WIN_BUSY;
            commit_pulse <= 1'b1;
          end
        end
        WIN_BUSY: begin
          ld_pend <= 1'b0;
          if (busy_done) st <= WIN_IDLE;
        end
        default: st <= WIN_IDLE;
      endcase
    end
  end

  assign loading      = (st == WIN_LOAD);
  assign busy         = (st == WIN_BUSY);
  assign commit_count = CNT_W'(count_set(MASK_MAX'(mask)));
endmodule

// File: rtl/pwl_load_ctrl_chk.sv
module pwl_load_ctrl_chk #(
  parameter int PAGE_W = 10,
  parameter int CNT_W  = 8,
  parameter int DEPTH  = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              loading,
  input logic              busy,
  input logic              commit_pulse,
  input logic [PAGE_W-1:0] commit_page,
  input logic [CNT_W-1:0]  commit_count,
  input logic              page_err,
  input logic              late_err,
  input logic              ev_reject_page,
  input logic              ev_reject_late
);
  logic rst_low_q = 1'b0;
  always_ff @(posedge clk) rst_low_q <= !rst_n;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst_low_q |-> (!busy && !loading && !commit_pulse && commit_count == '0));

  // R6
  commit_enters_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |-> (busy && !loading));

  // R6
  commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |=> !commit_pulse);

  // R8
  commit_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |-> (commit_count != '0 && commit_count <= CNT_W'(DEPTH)));

  // R4
  page_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject_page |=> page_err);

  // R5
  late_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject_late |=> late_err);

  // R7
  busy_no_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !loading);

  // R7
  busy_page_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(commit_page));

  // R7
  busy_count_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(commit_count));
endmodule

bind pwl_load_ctrl pwl_load_ctrl_chk #(
  .PAGE_W(PAGE_W), .CNT_W(CNT_W), .DEPTH(DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .loading(loading), .busy(busy),
  .commit_pulse(commit_pulse), .commit_page(commit_page),
  .commit_count(commit_count), .page_err(page_err), .late_err(late_err),
  .ev_reject_page(ev_reject_page), .ev_reject_late(ev_reject_late)
);

// File: tb/sim_pwl_load_ctrl.sv
`timescale 1ns/1ps
module sim_pwl_load_ctrl;
  localparam int REARM = 20;
  localparam int SIL   = 40;
  localparam int BUSYC = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1;
  logic [16:0] addr = '0;
  logic [7:0]  din = '0;
  logic [6:0]  rd_idx = '0;
  logic [7:0]  rd_data;
  logic        rd_valid, loading, busy, commit_pulse, page_err, late_err;
  logic [9:0]  commit_page;
  logic [7:0]  commit_count;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwl_load_ctrl #(.REARM_CYC(REARM), .SILENCE_CYC(SIL), .BUSY_CYC(BUSYC)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr), .din(din),
    .rd_idx(rd_idx), .rd_data(rd_data), .rd_valid(rd_valid), .loading(loading),
    .busy(busy), .commit_pulse(commit_pulse), .commit_page(commit_page),
    .commit_count(commit_count), .page_err(page_err), .late_err(late_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [16:0] mk(input logic [9:0] pg, input logic [6:0] off);
    return {pg, off};
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One byte load. Fall in cycle f; the task returns one cycle after the rise.
  task automatic load(input logic [16:0] a, input logic [7:0] d, input bit use_ce);
    if (use_ce) begin
      @(negedge clk); we_n = 1'b0;
      @(negedge clk); addr = a; din = ~d; ce_n = 1'b0;
      @(negedge clk); addr = ~a;
      @(negedge clk); din = d; ce_n = 1'b1;
      @(negedge clk); we_n = 1'b1;
    end else begin
      @(negedge clk); addr = a; din = ~d; ce_n = 1'b0; we_n = 1'b0;
      @(negedge clk); addr = ~a;
      @(negedge clk); din = d; we_n = 1'b1;
      @(negedge clk); ce_n = 1'b1; din = 8'h00;
    end
  endtask

  task automatic peek(input logic [6:0] idx, input string tag,
                      input logic [7:0] exp_d, input logic exp_v);
    rd_idx = idx; #1;
    check({tag, " rd_data"}, rd_data, exp_d);
    check({tag, " rd_valid"}, rd_valid, exp_v);
  endtask

  // Called one cycle after the last rise; checks the commit cycle and count.
  task automatic wait_commit(input int exp_cnt);
    repeat (SIL - 2) @(negedge clk);
    check("R6 commit not early", commit_pulse, 0);
    @(negedge clk);
    check("R6 commit on time", commit_pulse, 1);
    check("R6 busy with commit", busy, 1);
    check("R6 window closed", loading, 0);
    check("R8 commit_count", commit_count, exp_cnt);
  endtask

  task automatic t_reset();
    check("R1 loading", loading, 0);
    check("R1 busy", busy, 0);
    check("R1 commit", commit_pulse, 0);
    check("R1 errors", {page_err, late_err}, 0);
    check("R1 count", commit_count, 0);
  endtask

  task automatic t_single();
    load(mk(10'h3C1, 7'd17), 8'hA5, 0);
    check("R3 loading", loading, 1);
    check("R3 page", commit_page, 10'h3C1);
    peek(7'd17, "R8 loaded", 8'hA5, 1);
    peek(7'd18, "R8 erased", 8'hFF, 0);
    wait_commit(1);
    // R7: a load during busy is ignored
    load(mk(10'h3C1, 7'd40), 8'h11, 0);
    check("R7 no window in busy", loading, 0);
    check("R7 no flags in busy", {page_err, late_err}, 0);
    peek(7'd40, "R7 busy load dropped", 8'hFF, 0);
    check("R7 count kept", commit_count, 1);
    repeat (BUSYC - 5) @(negedge clk);
    check("R7 busy last cycle", busy, 1);
    @(negedge clk);
    check("R7 busy ended", busy, 0);
    check("R7 page kept", commit_page, 10'h3C1);
  endtask

  task automatic t_multi();
    load(mk(10'h2A5, 7'd3), 8'h11, 0);
    idle(2);
    load(mk(10'h2A5, 7'd3), 8'h22, 1);
    idle(2);
    load(mk(10'h2A5, 7'd90), 8'h33, 0);
    idle(2);
    load(mk(10'h2A5, 7'd0), 8'h44, 1);
    peek(7'd3, "R8 overwrite", 8'h22, 1);
    peek(7'd124, "R2 addr after fall ignored", 8'hFF, 0);
    peek(7'd90, "R2 data at rise", 8'h33, 1);
    peek(7'd0, "R2 ce strobe", 8'h44, 1);
    wait_commit(3);
    idle(BUSYC);
  endtask

  task automatic t_mismatch();
    load(mk(10'h155, 7'd5), 8'hAA, 0);
    idle(2);
    load(mk(10'h156, 7'd6), 8'hBB, 0);
    check("R4 page_err", page_err, 1);
    check("R4 page kept", commit_page, 10'h155);
    peek(7'd6, "R4 dropped", 8'hFF, 0);
    check("R4 window open", loading, 1);
    wait_commit(1);
    idle(BUSYC);
    check("R10 flag held", page_err, 1);
  endtask

  task automatic t_late();
    load(mk(10'h0F0, 7'd9), 8'h5C, 0);
    check("R10 page_err cleared", page_err, 0);
    check("R10 late_err clear", late_err, 0);
    idle(30);
    load(mk(10'h0F0, 7'd10), 8'h6D, 0);
    check("R5 late_err", late_err, 1);
    check("R5 page_err", page_err, 0);
    peek(7'd10, "R5 dropped", 8'hFF, 0);
    peek(7'd9, "R5 first kept", 8'h5C, 1);
    wait_commit(1);
    idle(BUSYC);
  endtask

  task automatic t_full();
    for (int i = 0; i < 128; i++) begin
      load(mk(10'h201, 7'(i)), 8'(i) ^ 8'h5A, 0);
      if (i != 127) idle(1);
    end
    check("R8 no errors full", {page_err, late_err}, 0);
    peek(7'd0, "R8 full first", 8'h5A, 1);
    peek(7'd77, "R8 full mid", 8'd77 ^ 8'h5A, 1);
    peek(7'd127, "R8 full last", 8'd127 ^ 8'h5A, 1);
    wait_commit(128);
    idle(BUSYC);
  endtask

  task automatic t_abort();
    load(mk(10'h011, 7'd2), 8'h77, 0);
    wait_commit(1);
    idle(3);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 busy aborted", busy, 0);
    check("R9 count cleared", commit_count, 0);
    ce_n = 1'b0; we_n = 1'b0;
    idle(2);
    ce_n = 1'b1; we_n = 1'b1;
    check("R1 no window in reset", loading, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    check("R1 no window after reset", loading, 0);
    check("R9 no commit", {commit_pulse, busy}, 0);
    peek(7'd2, "R9 mask cleared", 8'hFF, 0);
  endtask

  initial begin
    idle(3);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_single();
    t_multi();
    t_mismatch();
    t_late();
    t_full();
    t_abort();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule